// File: doc/BRIEF.md
# Dual-Memory Fixed-Priority Request Arbiter

This block sits between a processor, a DMA engine and two block-RAM controllers. The first memory holds working data. The processor can write it, prefetch from it and read from it, and the DMA engine reads it. The second memory collects results. The DMA engine writes it and the processor reads it.

Each memory has its own fixed ranking of the requesters that may reach it. In every cycle, and separately for each memory, the block picks the highest-ranked pending request. It raises that requester's acknowledge in the same cycle. There is no fairness and no aging.

The winner's command (address, write data and write enable) is captured into a register at the clock edge that ends the grant cycle. It is then presented to the memory controller for one cycle with a valid strobe. Acknowledge is decided cycle by cycle, so a streaming DMA read can lose one cycle to a processor access. The DMA holds its address through that cycle and resumes in the next cycle.

Top module: `mem_arbiter`

## Requirements
- R1: For the data memory the ranking is, from highest to lowest: processor write, processor prefetch, DMA read, processor read. In every cycle, exactly the highest-ranked asserted request of these four has its acknowledge high.
- R2: For the result memory the ranking is DMA write first, then processor read. In every cycle, exactly the highest-ranked asserted request of these two has its acknowledge high.
- R3: An acknowledge is high only in a cycle where its own request is high. At most one acknowledge per memory is high in any cycle.
- R4: When no higher-ranked data-memory request is pending, a DMA read is acknowledged in the same cycle it is raised. While a higher-ranked request stays pending, the DMA acknowledge stays low.
- R5: In the cycle after a memory grants a request, that memory's valid output is 1 and its address output equals the winner's address from the grant cycle. In the cycle after a cycle with no grant, valid is 0 and the address is 0.
- R6: The write-enable output of a memory is 1 only in the cycle after its writer (processor write for the data memory, DMA write for the result memory) won. The write-data output then equals the data the writer presented. In every other cycle both are 0.
- R7: The two memories are arbitrated independently. Requests to one memory never change the acknowledges or commands of the other.
- R8: While reset is low, all command outputs (valid, write enable, address, write data) of both memories are 0.
- R9: A DMA read burst that is interrupted by a processor write or prefetch loses its acknowledge only in the cycles where the higher-ranked request is high. It is acknowledged again in the next cycle on the same held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWrReq | input | 1 | Processor write request, data memory |
| cpuWrAddr | input | ADDR_W | Processor write address |
| cpuWrData | input | DATA_W | Processor write data |
| cpuWrAck | output | 1 | Processor write granted this cycle |
| cpuPfReq | input | 1 | Processor prefetch request, data memory |
| cpuPfAddr | input | ADDR_W | Prefetch address |
| cpuPfAck | output | 1 | Prefetch granted this cycle |
| dmaRdReq | input | 1 | DMA read request, data memory |
| dmaRdAddr | input | ADDR_W | DMA read address |
| dmaRdAck | output | 1 | DMA read granted this cycle |
| cpuRd0Req | input | 1 | Processor read request, data memory |
| cpuRd0Addr | input | ADDR_W | Processor read address, data memory |
| cpuRd0Ack | output | 1 | Processor data-memory read granted |
| dmaWrReq | input | 1 | DMA write request, result memory |
| dmaWrAddr | input | ADDR_W | DMA write address |
| dmaWrData | input | DATA_W | DMA write data |
| dmaWrAck | output | 1 | DMA write granted this cycle |
| cpuRd1Req | input | 1 | Processor read request, result memory |
| cpuRd1Addr | input | ADDR_W | Processor read address, result memory |
| cpuRd1Ack | output | 1 | Processor result-memory read granted |
| m0Valid | output | 1 | Data-memory command valid |
| m0We | output | 1 | Data-memory write enable |
| m0Addr | output | ADDR_W | Data-memory command address |
| m0WData | output | DATA_W | Data-memory write data |
| m1Valid | output | 1 | Result-memory command valid |
| m1We | output | 1 | Result-memory write enable |
| m1Addr | output | ADDR_W | Result-memory command address |
| m1WData | output | DATA_W | Result-memory write data |

## Verification
The hardest situation to reach is a DMA burst that is interrupted in the middle. It needs a long held DMA read with a single-cycle processor write or prefetch in the middle of it. Then the bench must see the acknowledge drop and return on the same address. Random requests seldom line this up. Directed sequences therefore build it, both with a one-cycle intrusion and with a two-cycle intrusion, and add a busy-start case where the DMA waits behind a pending prefetch. Random traffic at mixed request densities then covers the full priority table of both memories and the registered commands.

// File: rtl/mem_arbiter_pkg.sv
package mem_arbiter_pkg;
  // requester counts fixed by the two priority lists
  localparam int N0 = 4;  // data memory: cpuWr, cpuPf, dmaRd, cpuRd0 (index 0 highest)
  localparam int N1 = 2;  // result memory: dmaWr, cpuRd1
  localparam int W0 = 0;  // index of the writer on the data memory
  localparam int W1 = 0;  // index of the writer on the result memory

  typedef struct packed {
    logic [N0-1:0] grant0;
    logic [N1-1:0] grant1;
  } arb_strobe_t;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_slot
    assign grant[i]   = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/mem_arbiter_ctrl.sv
module mem_arbiter_ctrl
  import mem_arbiter_pkg::*;
(
  input  logic [N0-1:0] req0,
  input  logic [N1-1:0] req1,
  output arb_strobe_t   strobe
);
  logic [N0-1:0] g0;
  logic [N1-1:0] g1;

  prio_pick #(.N(N0)) u_pick0 (.req(req0), .grant(g0));
  prio_pick #(.N(N1)) u_pick1 (.req(req1), .grant(g1));

  assign strobe.grant0 = g0;
  assign strobe.grant1 = g1;
endmodule

// File: rtl/mem_arbiter_dp.sv
module mem_arbiter_dp
  import mem_arbiter_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arb_strobe_t          strobe,
  input  logic [N0*ADDR_W-1:0] addr0Flat,
  input  logic [N1*ADDR_W-1:0] addr1Flat,
  input  logic [DATA_W-1:0]    wdata0,
  input  logic [DATA_W-1:0]    wdata1,
  output logic                 m0Valid,
  output logic                 m0We,
  output logic [ADDR_W-1:0]    m0Addr,
  output logic [DATA_W-1:0]    m0WData,
  output logic                 m1Valid,
  output logic                 m1We,
  output logic [ADDR_W-1:0]    m1Addr,
  output logic [DATA_W-1:0]    m1WData
);
  logic [ADDR_W-1:0] selA0, selA1;

  // one-hot AND-OR multiplexers
  always_comb begin
    selA0 = '0;
    for (int i = 0; i < N0; i++)
      if (strobe.grant0[i]) selA0 = selA0 | addr0Flat[i*ADDR_W +: ADDR_W];
  end

  always_comb begin
    selA1 = '0;
    for (int i = 0; i < N1; i++)
      if (strobe.grant1[i]) selA1 = selA1 | addr1Flat[i*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m0Valid <= 1'b0;
      m0We    <= 1'b0;
      m0Addr  <= '0;
      m0WData <= '0;
      m1Valid <= 1'b0;
      m1We    <= 1'b0;
      m1Addr  <= '0;
      m1WData <= '0;
    end else begin
      m0Valid <= |strobe.grant0;
      m0We    <= strobe.grant0[W0];
      m0Addr  <= selA0;
      m0WData <= strobe.grant0[W0] ? wdata0 : '0;
      m1Valid <= |strobe.grant1;
      m1We    <= strobe.grant1[W1];
      m1Addr  <= selA1;
      m1WData <= strobe.grant1[W1] ? wdata1 : '0;
    end
  end
endmodule

// File: rtl/mem_arbiter.sv
module mem_arbiter
  import mem_arbiter_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrReq,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic              cpuWrAck,
  input  logic              cpuPfReq,
  input  logic [ADDR_W-1:0] cpuPfAddr,
  output logic              cpuPfAck,
  input  logic              dmaRdReq,
  input  logic [ADDR_W-1:0] dmaRdAddr,
  output logic              dmaRdAck,
  input  logic              cpuRd0Req,
  input  logic [ADDR_W-1:0] cpuRd0Addr,
  output logic              cpuRd0Ack,
  input  logic              dmaWrReq,
  input  logic [ADDR_W-1:0] dmaWrAddr,
  input  logic [DATA_W-1:0] dmaWrData,
  output logic              dmaWrAck,
  input  logic              cpuRd1Req,
  input  logic [ADDR_W-1:0] cpuRd1Addr,
  output logic              cpuRd1Ack,
  output logic              m0Valid,
  output logic              m0We,
  output logic [ADDR_W-1:0] m0Addr,
  output logic [DATA_W-1:0] m0WData,
  output logic              m1Valid,
  output logic              m1We,
  output logic [ADDR_W-1:0] m1Addr,
  output logic [DATA_W-1:0] m1WData
);
  arb_strobe_t strobe;

  // request vectors in priority order, index 0 highest
  logic [N0-1:0] req0;
  logic [N1-1:0] req1;
  assign req0 = {cpuRd0Req, dmaRdReq, cpuPfReq, cpuWrReq};
  assign req1 = {cpuRd1Req, dmaWrReq};

  mem_arbiter_ctrl u_ctrl (
    .req0  (req0),
    .req1  (req1),
    .strobe(strobe)
  );

  mem_arbiter_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr0Flat({cpuRd0Addr, dmaRdAddr, cpuPfAddr, cpuWrAddr}),
    .addr1Flat({cpuRd1Addr, dmaWrAddr}),
    .wdata0   (cpuWrData),
    .wdata1   (dmaWrData),
    .m0Valid  (m0Valid),
    .m0We     (m0We),
    .m0Addr   (m0Addr),
    .m0WData  (m0WData),
    .m1Valid  (m1Valid),
    .m1We     (m1We),
    .m1Addr   (m1Addr),
    .m1WData  (m1WData)
  );

  assign cpuWrAck  = strobe.grant0[0];
  assign cpuPfAck  = strobe.grant0[1];
  assign dmaRdAck  = strobe.grant0[2];
  assign cpuRd0Ack = strobe.grant0[3];
  assign dmaWrAck  = strobe.grant1[0];
  assign cpuRd1Ack = strobe.grant1[1];
endmodule

// File: rtl/mem_arbiter_chk.sv
module mem_arbiter_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuWrReq,
  input logic              cpuWrAck,
  input logic              cpuPfReq,
  input logic              cpuPfAck,
  input logic              dmaRdReq,
  input logic [ADDR_W-1:0] dmaRdAddr,
  input logic              dmaRdAck,
  input logic              cpuRd0Req,
  input logic              cpuRd0Ack,
  input logic              dmaWrReq,
  input logic [DATA_W-1:0] dmaWrData,
  input logic              dmaWrAck,
  input logic              cpuRd1Req,
  input logic              cpuRd1Ack,
  input logic              m0Valid,
  input logic              m0We,
  input logic [ADDR_W-1:0] m0Addr,
  input logic              m1Valid,
  input logic              m1We,
  input logic [DATA_W-1:0] m1WData
);
  // R1
  top_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrReq |-> cpuWrAck);

  // R1
  dma_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaRdAck |-> (!cpuWrReq && !cpuPfReq));

  // R2
  rd1_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRd1Ack |-> !dmaWrReq);

  // R3
  ack0_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cpuWrAck, cpuPfAck, dmaRdAck, cpuRd0Ack}));

  // R3
  ack1_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaWrAck, cpuRd1Ack}));

  // R3
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd0Ack |-> cpuRd0Req) and (cpuRd1Ack |-> cpuRd1Req) and (dmaRdAck |-> dmaRdReq));

  // R4
  dma_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRdReq && !cpuWrReq && !cpuPfReq) |-> dmaRdAck);

  // R5
  dma_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaRdAck |=> (m0Valid && !m0We && m0Addr == $past(dmaRdAddr)));

  // R6
  we0_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m0We) |-> $past(cpuWrReq));

  // R6
  we1_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaWrAck |=> (m1We && m1WData == $past(dmaWrData)));

  // R5
  idle1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaWrReq && !cpuRd1Req) |=> !m1Valid);
endmodule

bind mem_arbiter mem_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mem_arbiter_bench.sv
`timescale 1ns/1ps
module mem_arbiter_bench;
  localparam int AW = 13;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic cpuWrReq = 0, cpuPfReq = 0, dmaRdReq = 0, cpuRd0Req = 0, dmaWrReq = 0, cpuRd1Req = 0;
  logic [AW-1:0] cpuWrAddr = 0, cpuPfAddr = 0, dmaRdAddr = 0, cpuRd0Addr = 0, dmaWrAddr = 0, cpuRd1Addr = 0;
  logic [DW-1:0] cpuWrData = 0, dmaWrData = 0;
  logic cpuWrAck, cpuPfAck, dmaRdAck, cpuRd0Ack, dmaWrAck, cpuRd1Ack;
  logic m0Valid, m0We, m1Valid, m1We;
  logic [AW-1:0] m0Addr, m1Addr;
  logic [DW-1:0] m0WData, m1WData;

  mem_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_mem_arbiter (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // expected registered command for the next cycle
  logic eV0 = 0, eWe0 = 0, eV1 = 0, eWe1 = 0;
  logic [AW-1:0] eA0 = 0, eA1 = 0;
  logic [DW-1:0] eD0 = 0, eD1 = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pick0(input logic [3:0] r);
    if (r[0]) return 4'b0001;
    else if (r[1]) return 4'b0010;
    else if (r[2]) return 4'b0100;
    else if (r[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic [1:0] pick1(input logic [1:0] r);
    if (r[0]) return 2'b01;
    else if (r[1]) return 2'b10;
    return 2'b00;
  endfunction

  // one cycle: check last command, drive new requests, check acks
  task automatic step(input logic [3:0] r0, input logic [1:0] r1, input bit newAddr);
    logic [3:0] g0;
    logic [1:0] g1;
    @(negedge clk);
    chk("R5 m0Valid", m0Valid, eV0);
    chk("R5 m0Addr", m0Addr, eA0);
    chk("R6 m0We", m0We, eWe0);
    chk("R6 m0WData", m0WData, eD0);
    chk("R5 m1Valid", m1Valid, eV1);
    chk("R5 m1Addr", m1Addr, eA1);
    chk("R6 m1We", m1We, eWe1);
    chk("R6 m1WData", m1WData, eD1);
    {cpuRd0Req, dmaRdReq, cpuPfReq, cpuWrReq} = r0;
    {cpuRd1Req, dmaWrReq} = r1;
    if (newAddr) begin
      cpuWrAddr = AW'($urandom); cpuPfAddr = AW'($urandom); dmaRdAddr = AW'($urandom);
      cpuRd0Addr = AW'($urandom); dmaWrAddr = AW'($urandom); cpuRd1Addr = AW'($urandom);
    end
    cpuWrData = $urandom; dmaWrData = $urandom;
    #1;
    g0 = pick0(r0);
    g1 = pick1(r1);
    chk("R1 acks0", {cpuRd0Ack, dmaRdAck, cpuPfAck, cpuWrAck}, g0);
    chk("R2 acks1", {cpuRd1Ack, dmaWrAck}, g1);
    eV0 = |g0; eWe0 = g0[0];
    eA0 = g0[0] ? cpuWrAddr : g0[1] ? cpuPfAddr : g0[2] ? dmaRdAddr : g0[3] ? cpuRd0Addr : '0;
    eD0 = g0[0] ? cpuWrData : '0;
    eV1 = |g1; eWe1 = g1[0];
    eA1 = g1[0] ? dmaWrAddr : g1[1] ? cpuRd1Addr : '0;
    eD1 = g1[0] ? dmaWrData : '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    void'($urandom(32'h5eed_1234));
    // R8: reset state with requests raised
    repeat (2) @(negedge clk);
    cpuWrReq = 1; dmaWrReq = 1; cpuWrData = 32'hffff_ffff; cpuWrAddr = '1;
    @(negedge clk);
    chk("R8 m0 cmd", {m0Valid, m0We, m0Addr, m0WData}, 0);
    chk("R8 m1 cmd", {m1Valid, m1We, m1Addr, m1WData}, 0);
    cpuWrReq = 0; dmaWrReq = 0;
    @(negedge clk);
    rstN = 1;

    // R4: idle arbiter, DMA read acknowledged in the raising cycle
    step(4'b0000, 2'b00, 1);
    step(4'b0100, 2'b00, 1);
    chk("R4 idle dma ack", dmaRdAck, 1'b1);

    // R4: busy start, DMA waits behind prefetch while holding its address
    step(4'b0010, 2'b00, 1);
    held = dmaRdAddr;
    step(4'b0110, 2'b00, 0);
    chk("R4 dma withheld", dmaRdAck, 1'b0);
    step(4'b0110, 2'b00, 0);
    chk("R4 dma still withheld", dmaRdAck, 1'b0);
    step(4'b0100, 2'b00, 0);
    chk("R4 dma ack after busy", dmaRdAck, 1'b1);
    chk("R4 held addr", dmaRdAddr, held);

    // R9: burst with one-cycle processor write intrusion
    step(4'b0100, 2'b00, 1);
    step(4'b0101, 2'b00, 0);
    chk("R9 ack drops", dmaRdAck, 1'b0);
    held = dmaRdAddr;
    step(4'b0100, 2'b00, 0);
    chk("R9 ack resumes", dmaRdAck, 1'b1);
    step(4'b0100, 2'b00, 0);
    @(negedge clk);
    chk("R9 resumed addr", m0Addr, held);
    chk("R9 resumed read", {m0Valid, m0We}, 2'b10);
    // R9: two-cycle prefetch intrusion, lowest reader also waiting
    step(4'b1110, 2'b00, 0);
    chk("R9 two-cycle drop a", dmaRdAck, 1'b0);
    step(4'b1110, 2'b00, 0);
    chk("R9 two-cycle drop b", dmaRdAck, 1'b0);
    step(4'b1100, 2'b00, 0);
    chk("R9 resume after two", dmaRdAck, 1'b1);
    chk("R1 lowest reader waits", cpuRd0Ack, 1'b0);
    step(4'b1000, 2'b00, 1);
    chk("R1 lowest reader alone", cpuRd0Ack, 1'b1);

    // R7: result memory unaffected by a full data-memory load
    step(4'b1111, 2'b10, 1);
    chk("R7 rd1 ack under load", cpuRd1Ack, 1'b1);
    step(4'b0000, 2'b11, 1);
    chk("R7 dma write wins", dmaWrAck, 1'b1);
    step(4'b1111, 2'b00, 1);
    chk("R7 no result ack", {dmaWrAck, cpuRd1Ack}, 2'b00);
    // R3: no ack without request
    step(4'b0000, 2'b00, 1);
    chk("R3 no acks idle", {cpuWrAck, cpuPfAck, dmaRdAck, cpuRd0Ack, dmaWrAck, cpuRd1Ack}, 0);

    // random traffic at varying density
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r0;
      logic [1:0] r1;
      int dens;
      dens = (i / 500) % 3;
      for (int b = 0; b < 4; b++) r0[b] = ($urandom % 4) < dens + 1;
      for (int b = 0; b < 2; b++) r1[b] = ($urandom % 4) < dens + 1;
      step(r0, r1, 1);
    end
    step(4'b0000, 2'b00, 1);
    step(4'b0000, 2'b00, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule